// File: doc/BRIEF.md
# Pretrigger Reference-Capture Controller

This block runs a circular capture buffer for sampled input words. Software (or a neighbouring sequencer) pulses `arm`. The block then waits for the selected edge of `start_trig`. From the cycle after that edge it stores `smp_data` on every selected edge of the sample strobe `smp_clk`, unless the level-sensitive pause input is active. Writes go into an internal RAM that wraps at the run-time length `cfg_len`. Once at least `cfg_pre` words have been stored, the selected edge of `ref_trig` is accepted. The block then stores exactly `cfg_len - cfg_pre` further words and stops. While it waits for that reference edge, the oldest words are overwritten and a sticky overflow flag records that this happened.

On completion `done` rises and `start_idx` gives the address of the oldest word still held. Reading addresses `start_idx`, `start_idx+1`, and so on, modulo `cfg_len`, returns the capture in time order. All inputs are synchronous to `clk`, and `smp_clk` is treated as a strobe sampled in that clock domain.

Readout uses a valid/ready request channel. A request is taken in a cycle where both `rd_valid` and `rd_ready` are high. `rd_ready` is low while capture is writing, so the requester must hold `rd_valid` and `rd_addr` until it is accepted. The returned word appears one cycle after acceptance, qualified by `rd_data_valid`. The return path has no back-pressure, so the consumer must take the word in that cycle. The configuration must satisfy 1 <= `cfg_pre` < `cfg_len` <= DEPTH, and it is held stable from `arm` to the end of readout.

Top module: `refcap_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `overflow` and `rd_data_valid` are 0, `start_idx` is 0 and `rd_ready` is 1.
- R2: A pulse on `arm` in any state restarts the block in the waiting-for-start state and clears `done`, `overflow` and the fill count. Sample edges arriving before the start edge, and the sample edge in the start-edge cycle itself, are not stored. The start edge is rising when `start_fall`=0 and falling when `start_fall`=1.
- R3: A sample is taken on a rising `smp_clk` edge when `smp_fall`=0 and on a falling edge when `smp_fall`=1. Each taken sample writes one word at the write address, which starts at 0 after `arm` and advances by one, wrapping from `cfg_len-1` to 0.
- R4: While `pause_in` equals `pause_high`, sample edges are ignored and nothing is written.
- R5: A reference edge (rising when `ref_fall`=0, falling when `ref_fall`=1) is accepted only if at least `cfg_pre` samples were stored before that cycle. Otherwise it is ignored. A sample taken in the same cycle as an accepted reference edge counts as a pretrigger sample.
- R6: After an accepted reference edge, exactly `cfg_len - cfg_pre` more samples are stored. On the cycle after the last one, `done` is 1 and `busy` is 0. `busy` is 1 exactly while samples are being collected.
- R7: In the pretrigger phase, once `cfg_len` samples are held, each further sample overwrites the oldest one and sets `overflow`, which stays set until the next `arm`.
- R8: At completion `start_idx` equals the write address following the last stored sample. Reading `cfg_len` consecutive addresses from it, modulo `cfg_len`, returns the last `cfg_len` stored samples oldest-first.
- R9: Once done, the block is not retriggerable. Start edges, reference edges and sample edges leave `done`, `start_idx` and the buffer contents unchanged until the next `arm`.
- R10: `rd_ready` is 0 while `busy` is 1 and 1 otherwise. An accepted read returns the word at `rd_addr` on `rd_data` in the next cycle, with `rd_data_valid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that restarts an acquisition |
| start_trig | input | 1 | Start trigger signal |
| start_fall | input | 1 | 1 selects the falling start edge |
| ref_trig | input | 1 | Reference trigger signal |
| ref_fall | input | 1 | 1 selects the falling reference edge |
| smp_clk | input | 1 | Sample strobe |
| smp_fall | input | 1 | 1 selects the falling sample edge |
| pause_in | input | 1 | Pause level |
| pause_high | input | 1 | Level of `pause_in` that pauses |
| cfg_len | input | CW | Buffer length in words |
| cfg_pre | input | CW | Pretrigger sample count |
| smp_data | input | DW | Word stored on a taken sample |
| busy | output | 1 | Collecting samples |
| done | output | 1 | Capture complete, held until `arm` |
| overflow | output | 1 | Oldest pretrigger data was overwritten |
| start_idx | output | AW | Address of the oldest stored word |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read word |
| rd_data_valid | output | 1 | `rd_data` holds a returned word |

## Verification
The case that needs care is a sample edge and a reference edge in the same clock cycle. The bench provokes it twice. The first time, the sample in that cycle is the one that brings the stored count up to `cfg_pre`, so the edge must be ignored. The second time, the count already meets the threshold, so the edge is accepted and that cycle's sample is counted before the trigger. A behavioural model follows each case, and the result is judged both by the cycle on which `done` rises and by the time-ordered readout. A pause during the posttrigger phase and an `arm` issued in the middle of a capture are exercised the same way.

// File: rtl/refcap_pkg.sv
package refcap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_POST,
    ST_DONE
  } cap_state_e;

  localparam int NEV    = 3;
  localparam int EV_SMP = 0;
  localparam int EV_STA = 1;
  localparam int EV_REF = 2;
endpackage

// File: rtl/refcap_edge.sv
module refcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic fall_sel,
  output logic ev
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign ev = fall_sel ? (prev_q & ~sig) : (~prev_q & sig);
endmodule

// File: rtl/refcap_ram.sv
module refcap_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/refcap_fsm.sv
module refcap_fsm
  import refcap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          start_ev,
  input  logic          ref_ev,
  input  logic          smp_ev,
  input  logic          paused,
  input  logic [CW-1:0] cfg_len,
  input  logic [CW-1:0] cfg_pre,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output cap_state_e    state,
  output logic [AW-1:0] start_idx,
  output logic          done,
  output logic          overflow
);
  logic [AW-1:0] wp_q, wp_nxt;
  logic [CW-1:0] fill_q, post_q;
  logic          smp_ok, at_last, ref_ok, collecting;

  assign smp_ok     = smp_ev && !paused;
  assign collecting = (state == ST_PRE) || (state == ST_POST);
  assign at_last    = (CW'(wp_q) == cfg_len - CW'(1));
  assign wp_nxt     = at_last ? '0 : wp_q + AW'(1);
  assign ref_ok     = ref_ev && (fill_q >= cfg_pre);
  assign wr_en      = smp_ok && collecting && !arm;
  assign wr_addr    = wp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wp_q      <= '0;
      fill_q    <= '0;
      post_q    <= '0;
      start_idx <= '0;
      done      <= 1'b0;
      overflow  <= 1'b0;
    end else if (arm) begin
      state    <= ST_WAIT;
      wp_q     <= '0;
      fill_q   <= '0;
      post_q   <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: if (start_ev) state <= ST_PRE;
        ST_PRE: begin
          if (smp_ok) begin
            wp_q <= wp_nxt;
            if (fill_q == cfg_len) overflow <= 1'b1;
            else                   fill_q   <= fill_q + CW'(1);
          end
          if (ref_ok) begin
            state  <= ST_POST;
            post_q <= cfg_len - cfg_pre;
          end
        end
        ST_POST: begin
          if (smp_ok) begin
            wp_q   <= wp_nxt;
            post_q <= post_q - CW'(1);
            if (post_q == CW'(1)) begin
              state     <= ST_DONE;
              done      <= 1'b1;
              start_idx <= wp_nxt;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/refcap_ctrl.sv
module refcap_ctrl
  import refcap_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          start_trig,
  input  logic          start_fall,
  input  logic          ref_trig,
  input  logic          ref_fall,
  input  logic          smp_clk,
  input  logic          smp_fall,
  input  logic          pause_in,
  input  logic          pause_high,
  input  logic [CW-1:0] cfg_len,
  input  logic [CW-1:0] cfg_pre,
  input  logic [DW-1:0] smp_data,
  output logic          busy,
  output logic          done,
  output logic          overflow,
  output logic [AW-1:0] start_idx,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_valid
);
  logic [NEV-1:0] sig_vec, fall_vec, ev_vec;
  cap_state_e     state;
  logic           wr_en, rd_fire;
  logic [AW-1:0]  wr_addr;

  assign sig_vec  = {ref_trig, start_trig, smp_clk};
  assign fall_vec = {ref_fall, start_fall, smp_fall};

  for (genvar g = 0; g < NEV; g++) begin : g_edge
    refcap_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig      (sig_vec[g]),
      .fall_sel (fall_vec[g]),
      .ev       (ev_vec[g])
    );
  end

  refcap_fsm #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .start_ev  (ev_vec[EV_STA]),
    .ref_ev    (ev_vec[EV_REF]),
    .smp_ev    (ev_vec[EV_SMP]),
    .paused    (pause_in == pause_high),
    .cfg_len   (cfg_len),
    .cfg_pre   (cfg_pre),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .state     (state),
    .start_idx (start_idx),
    .done      (done),
    .overflow  (overflow)
  );

  assign busy     = (state == ST_PRE) || (state == ST_POST);
  assign rd_ready = !busy;
  assign rd_fire  = rd_valid && rd_ready;

  refcap_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (smp_data),
    .re    (rd_fire),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_valid <= 1'b0;
    else        rd_data_valid <= rd_fire;
  end
endmodule

// File: rtl/refcap_ctrl_chk.sv
module refcap_ctrl_chk #(
  parameter int AW = 4,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          pause_in,
  input logic          pause_high,
  input logic          busy,
  input logic          done,
  input logic          overflow,
  input logic [CW-1:0] cfg_len,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_data_valid,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && !overflow));

  a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (CW'(wr_addr) < cfg_len));

  a_r4_pause_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_in == pause_high) |-> !wr_en);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !arm) |=> overflow);

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  a_r10_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_data_valid);

  a_r10_no_spurious_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rd_data_valid);

  a_r10_no_read_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_ready);
endmodule

bind refcap_ctrl refcap_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .arm           (arm),
  .pause_in      (pause_in),
  .pause_high    (pause_high),
  .busy          (busy),
  .done          (done),
  .overflow      (overflow),
  .cfg_len       (cfg_len),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .rd_data_valid (rd_data_valid),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr)
);

// File: tb/refcap_ctrl_bench.sv
module refcap_ctrl_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          b_arm, b_st, b_stf, b_ref, b_reff, b_sc, b_scf, b_pz, b_pzh, b_rv;
  logic [CW-1:0] b_len, b_pre;
  logic [DW-1:0] b_din;
  logic [AW-1:0] b_ra;
  logic          busy, done, overflow, rd_ready, rd_data_valid;
  logic [AW-1:0] start_idx;
  logic [DW-1:0] rd_data;

  refcap_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_refcap_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(b_arm),
    .start_trig(b_st), .start_fall(b_stf),
    .ref_trig(b_ref), .ref_fall(b_reff),
    .smp_clk(b_sc), .smp_fall(b_scf),
    .pause_in(b_pz), .pause_high(b_pzh),
    .cfg_len(b_len), .cfg_pre(b_pre), .smp_data(b_din),
    .busy(busy), .done(done), .overflow(overflow), .start_idx(start_idx),
    .rd_valid(b_rv), .rd_ready(rd_ready), .rd_addr(b_ra),
    .rd_data(rd_data), .rd_data_valid(rd_data_valid)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model: 0 idle, 1 wait, 2 pre, 3 post, 4 done
  int mst, mfill, mpost, mwp, mstart;
  bit mdone, movf, mrdv;
  bit p_st, p_ref, p_sc;
  int hist[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit edge_of(input bit prev, input bit cur, input bit fall);
    return fall ? (prev && !cur) : (!prev && cur);
  endfunction

  task automatic model_step();
    bit sev, stev, rev, pz, smp, acc, rdy;
    int len, pre;
    len  = int'(b_len);
    pre  = int'(b_pre);
    sev  = edge_of(p_sc, b_sc, b_scf);
    stev = edge_of(p_st, b_st, b_stf);
    rev  = edge_of(p_ref, b_ref, b_reff);
    p_sc = b_sc; p_st = b_st; p_ref = b_ref;
    pz   = (b_pz == b_pzh);
    smp  = sev && !pz;
    rdy  = !(mst == 2 || mst == 3);
    mrdv = b_rv && rdy;
    if (b_arm) begin
      mst = 1; mwp = 0; mfill = 0; mpost = 0; mdone = 0; movf = 0;
      hist.delete();
    end else if (mst == 1) begin
      if (stev) mst = 2;
    end else if (mst == 2) begin
      acc = rev && (mfill >= pre);
      if (smp) begin
        hist.push_back(int'(b_din));
        if (hist.size() > len) void'(hist.pop_front());
        mwp = (mwp + 1) % len;
        if (mfill == len) movf = 1; else mfill++;
      end
      if (acc) begin mst = 3; mpost = len - pre; end
    end else if (mst == 3) begin
      if (smp) begin
        hist.push_back(int'(b_din));
        if (hist.size() > len) void'(hist.pop_front());
        mwp = (mwp + 1) % len;
        mpost--;
        if (mpost == 0) begin mst = 4; mdone = 1; mstart = mwp; end
      end
    end
  endtask

  task automatic cyc();
    bit mbusy;
    @(posedge clk);
    model_step();
    @(negedge clk);
    mbusy = (mst == 2 || mst == 3);
    check(busy == mbusy, "R6 busy", int'(busy), int'(mbusy));
    check(done == mdone, "R6 R9 done", int'(done), int'(mdone));
    check(overflow == movf, "R7 overflow", int'(overflow), int'(movf));
    check(int'(start_idx) == mstart, "R8 start_idx", int'(start_idx), mstart);
    check(rd_ready == !mbusy, "R10 rd_ready", int'(rd_ready), int'(!mbusy));
    check(rd_data_valid == mrdv, "R10 rd_data_valid", int'(rd_data_valid), int'(mrdv));
  endtask

  task automatic smp(input logic [DW-1:0] d);
    b_din = d;
    b_sc = ~b_sc; cyc();
    b_sc = ~b_sc; cyc();
  endtask

  task automatic pulse_arm();
    b_arm = 1'b1; cyc(); b_arm = 1'b0;
  endtask

  task automatic pulse_start();
    b_st = ~b_st; cyc(); b_st = ~b_st; cyc();
  endtask

  task automatic pulse_ref();
    b_ref = ~b_ref; cyc(); b_ref = ~b_ref; cyc();
  endtask

  task automatic readout(input string tag);
    int len;
    len = int'(b_len);
    for (int k = 0; k < len; k++) begin
      b_rv = 1'b1;
      b_ra = AW'((mstart + k) % len);
      cyc();
      check(int'(rd_data) == hist[k], tag, int'(rd_data), hist[k]);
    end
    b_rv = 1'b0;
    cyc();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    b_arm = 0; b_st = 0; b_stf = 0; b_ref = 0; b_reff = 0; b_sc = 0; b_scf = 0;
    b_pz = 0; b_pzh = 1; b_rv = 0; b_ra = '0; b_din = '0;
    b_len = CW'(8); b_pre = CW'(3);
    mst = 0; mfill = 0; mpost = 0; mwp = 0; mstart = 0; mdone = 0; movf = 0; mrdv = 0;
    p_st = 0; p_ref = 0; p_sc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(!busy && !done && !overflow && !rd_data_valid, "R1 flags", int'(busy|done|overflow), 0);
    check(start_idx == '0, "R1 start_idx", int'(start_idx), 0);
    check(rd_ready == 1'b1, "R1 rd_ready", int'(rd_ready), 1);
    cyc();

    // Scenario A: rising edges, pause active high, len 8, pre 3
    pulse_arm();
    smp(8'hA0); smp(8'hA1);            // R2 before start: ignored
    b_st = 1; b_sc = 1; b_din = 8'hA2; cyc(); // R2 start and sample in one cycle
    b_st = 0; b_sc = 0; cyc();
    check(busy == 1'b1, "R2 started", int'(busy), 1);
    smp(8'h01);
    pulse_ref();                         // R5 early reference ignored
    check(busy == 1'b1 && !done, "R5 early ref ignored", int'(busy), 1);
    smp(8'h02);
    b_din = 8'h03; b_sc = 1; b_ref = 1; cyc(); // R5 same cycle, count reaches pre: ignored
    b_sc = 0; b_ref = 0; cyc();
    smp(8'h04);
    b_din = 8'h05; b_sc = 1; b_ref = 1; cyc(); // R5 accepted, sample is pretrigger
    b_sc = 0; b_ref = 0; cyc();
    smp(8'h06); smp(8'h07);
    b_pz = 1; smp(8'hEE); b_pz = 0;      // R4 paused sample ignored
    smp(8'h08); smp(8'h09);
    check(busy == 1'b1, "R6 one post sample left", int'(busy), 1);
    smp(8'h0A);
    check(done == 1'b1 && start_idx == AW'(2), "R6 R8 done idx", int'(start_idx), 2);
    check(overflow == 1'b0, "R7 no overflow", int'(overflow), 0);
    pulse_start(); pulse_ref(); smp(8'hBB);  // R9 not retriggerable
    check(done == 1'b1 && busy == 1'b0, "R9 stays done", int'(done), 1);
    readout("R8 R3 R4 readout A");

    // Scenario B: falling edges, pause active low, len 16, pre 4, overflow
    b_stf = 1; b_reff = 1; b_scf = 1; b_pzh = 0; b_pz = 1;
    b_len = CW'(16); b_pre = CW'(4);
    cyc();
    pulse_arm();
    check(!done && !overflow, "R2 arm clears", int'(done), 0);
    smp(8'hC0);                          // R2 before start
    pulse_start();
    for (int i = 0; i < 20; i++) smp(8'(8'h10 + i));
    check(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
    b_pz = 0; smp(8'hDD); b_pz = 1;      // R4 active-low pause
    pulse_ref();
    for (int i = 0; i < 12; i++) smp(8'(8'h40 + i));
    check(done == 1'b1 && start_idx == AW'(0), "R6 R8 wrap idx", int'(start_idx), 0);
    check(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
    readout("R8 R3 readout B");

    // Scenario C: rising, len 5, pre 4, arm mid capture
    b_stf = 0; b_reff = 0; b_scf = 0; b_pzh = 1; b_pz = 0;
    b_len = CW'(5); b_pre = CW'(4);
    cyc();
    pulse_arm();
    pulse_start();
    smp(8'h71); smp(8'h72);
    pulse_arm();                         // R2 restart mid capture
    check(busy == 1'b0, "R2 restart waits", int'(busy), 0);
    pulse_start();
    for (int i = 0; i < 6; i++) smp(8'(8'h80 + i));
    check(overflow == 1'b1, "R7 overflow C", int'(overflow), 1);
    pulse_ref();
    smp(8'h90);
    check(done == 1'b1 && start_idx == AW'(2), "R6 R8 idx C", int'(start_idx), 2);
    readout("R8 readout C");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule